// File: doc/BRIEF.md
# Three-Wire Serial Control Port Slave

This block is the slave end of a three-wire control bus driven by a microcontroller: a serial clock, a mode line and a bidirectional data line. While the mode line is low the controller sends one selection byte. That byte carries a transfer code and a device address. While the mode line is high the controller sends, or reads back, the bytes of one register operation. The block turns these serial transactions into parallel accesses on a bank of registers with 7-bit addresses and 16-bit values. The bank is held outside this block. A write appears as a one-cycle strobe with the register number and value. A read appears as a one-cycle request. The register bank answers it in the same cycle with data and an existence flag.

All three bus lines are resynchronised into the system clock. Input bits are taken on rising serial-clock edges and output bits change after falling edges. A read takes two visits to the bus. The first visit names the register (prepare). The second visit fetches three bytes: the echoed register number with a validity flag, the high data byte, then the low data byte. Two address pins choose two bits of the device address, so four slaves can share one bus.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset, the first rising edge of the serial clock only wakes the port and carries no bit. A selection byte that overlaps that edge therefore has only 7 bits and is not accepted. Transfers sent after the wake-up edge are accepted.
- R2: Each bit is taken on a rising serial-clock edge, least significant bit first within every byte.
- R3: The selection byte matches only when bits 7:4 equal 4'b0001 and bits 3:2 equal `dev_sel_i`. With any other address the data phase that follows is ignored.
- R4: Selection-byte bits 1:0 give the transfer code. 2'b10 means write or prepare read, and 2'b11 means read. 2'b00 and 2'b01 cause the following data phase to be ignored.
- R5: A write data phase carries a register byte with bit 0 = 0 and the register number in bits 7:1, then the high value byte, then the low value byte. It produces a single-cycle `wr_stb_o` with `wr_reg_o` and `wr_data_o`.
- R6: Once a write has completed, further bytes in the same data phase are ignored. A new selection phase is needed for each register.
- R7: A register byte with bit 0 = 1 records the register for a later read and presents it on `rd_reg_o`. It does not strobe a write.
- R8: A matching read selection gives one single-cycle `rd_req_o`. The device then returns three bytes, each least significant bit first: {register number, flag} with flag in bit 0 (0 if `rd_valid_i` was high, 1 if not), then data bits 15:8, then bits 7:0. Output bits change only after falling serial-clock edges.
- R9: `ser_dat_oe` rises only when the mode line goes high after a matching read selection. It drops when the mode line goes low, and it is never raised during a write.
- R10: A selection phase with fewer than 8 clock pulses causes the following data phase to be ignored.
- R11: `wr_reg_o` and `wr_data_o` are zero after reset and change only together with a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bus clock |
| ser_mode_i | input | 1 | Mode line: low for selection, high for data |
| ser_dat_i | input | 1 | Serial data from the controller |
| ser_dat_o | output | 1 | Serial data returned by the slave |
| ser_dat_oe | output | 1 | Drive enable for the data line |
| dev_sel_i | input | 2 | Device address bits 3:2 |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_reg_o | output | 7 | Register number of the last write |
| wr_data_o | output | 16 | Value of the last write |
| rd_req_o | output | 1 | One-cycle register read request |
| rd_reg_o | output | 7 | Register chosen by the last prepare read |
| rd_data_i | input | 16 | Register value, valid during `rd_req_o` |
| rd_valid_i | input | 1 | High when the requested register exists, valid during `rd_req_o` |

## Verification
A wrong bit counter or a wrong phase state shows at the ports within one transaction. The write strobe goes missing, comes twice, or carries a register number and value that are shifted by one bit. Errors in the read path show on the data line within the 24 returned bits. A bad transmit order swaps the echo byte and the data bytes. A stale prepared register shows as the wrong echoed number. A bad enable state leaves the line driven after the mode line falls. Each case is therefore checked at the end of its own transaction, and the held write outputs are checked again after frames that must be ignored.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;

   localparam int unsigned BYTE_W = 8;

   // transfer codes carried in selection-byte bits 1:0
   localparam logic [1:0] CODE_WRITE = 2'b10;
   localparam logic [1:0] CODE_READ  = 2'b11;

   typedef enum logic [1:0] {
      XFER_NONE,
      XFER_WRITE,
      XFER_READ
   } xfer_e;

   typedef enum logic [2:0] {
      SES_IDLE,
      SES_REGSEL,
      SES_WDATA,
      SES_RDOUT,
      SES_DONE
   } ses_e;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] lvl_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_line_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= din_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_st[s-1].q;
         end
      end
   end

   assign lvl_o = g_st[STAGES-1].q;

endmodule

// File: rtl/tw_addr_decode.sv
module tw_addr_decode
   import tw_ctrl_pkg::*;
#(
   parameter int unsigned          SEL_W    = 2,
   parameter int unsigned          DEV_HI_W = 4,
   parameter logic [DEV_HI_W-1:0]  DEV_HI   = 4'b0001
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [SEL_W-1:0]  sel_i,
   output xfer_e             xfer_o
);

   if (SEL_W + DEV_HI_W + 2 != BYTE_W) begin : g_bad_split
      $error("tw_addr_decode: address fields must fill one byte");
   end

   logic hit;
   assign hit = (byte_i[BYTE_W-1 -: DEV_HI_W] == DEV_HI) &&
                (byte_i[2 +: SEL_W] == sel_i);

   always_comb begin
      xfer_o = XFER_NONE;
      if (hit) begin
         case (byte_i[1:0])
            CODE_WRITE: xfer_o = XFER_WRITE;
            CODE_READ:  xfer_o = XFER_READ;
            default:    xfer_o = XFER_NONE;
         endcase
      end
   end

endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift #(
   parameter int unsigned WIDTH = 24,
   parameter logic        FILL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             shift_i,
   output logic             bit_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("tw_tx_shift: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_q <= '1;
      else if (load_i)  tx_q <= load_val_i;
      else if (shift_i) tx_q <= {FILL, tx_q[WIDTH-1:1]};
   end

   assign bit_o = tx_q[0];

endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
   import tw_ctrl_pkg::*;
#(
   parameter int unsigned          DATA_W      = 16,
   parameter int unsigned          REG_AW      = 7,
   parameter int unsigned          SEL_W       = 2,
   parameter int unsigned          DEV_HI_W    = 4,
   parameter logic [DEV_HI_W-1:0]  DEV_HI      = 4'b0001,
   parameter int unsigned          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_mode_i,
   input  logic              ser_dat_i,
   output logic              ser_dat_o,
   output logic              ser_dat_oe,
   input  logic [SEL_W-1:0]  dev_sel_i,
   output logic              wr_stb_o,
   output logic [REG_AW-1:0] wr_reg_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              rd_req_o,
   output logic [REG_AW-1:0] rd_reg_o,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_valid_i
);

   localparam int unsigned DATA_BYTES = DATA_W / BYTE_W;
   localparam int unsigned TX_W       = DATA_W + BYTE_W;
   localparam int unsigned BCNT_W     = $clog2(BYTE_W + 1);
   localparam int unsigned DBC_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

   if (DATA_W % BYTE_W != 0 || DATA_W < BYTE_W) begin : g_bad_data
      $error("tw_ctrl_slave: DATA_W must be a whole number of bytes");
   end
   if (REG_AW + 1 != BYTE_W) begin : g_bad_reg
      $error("tw_ctrl_slave: register number plus flag must fill one byte");
   end

   // ---------------- line synchronisation and edges ----------------
   logic [2:0] sync_lvl;
   logic       sclk_l, mode_l, dat_l;
   logic       sclk_q, mode_q;
   logic       sclk_rise, sclk_fall, mode_rise, mode_fall;

   tw_line_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din_i ({ser_dat_i, ser_mode_i, ser_clk_i}),
      .lvl_o (sync_lvl)
   );

   assign sclk_l = sync_lvl[0];
   assign mode_l = sync_lvl[1];
   assign dat_l  = sync_lvl[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         mode_q <= 1'b0;
      end else begin
         sclk_q <= sclk_l;
         mode_q <= mode_l;
      end
   end

   assign sclk_rise = sclk_l & ~sclk_q;
   assign sclk_fall = ~sclk_l & sclk_q;
   assign mode_rise = mode_l & ~mode_q;
   assign mode_fall = ~mode_l & mode_q;

   // ---------------- receive path ----------------
   logic              awake;
   ses_e              ses;
   logic [BCNT_W-1:0] bit_cnt;
   logic [BYTE_W-2:0] rx_hold;
   logic [BYTE_W-1:0] byte_full;
   logic              last_bit;
   logic              take_bit;
   xfer_e             xfer;
   logic [DBC_W-1:0]  dbyte_cnt;
   logic [REG_AW-1:0] wr_reg_pend;
   logic [REG_AW-1:0] prep_reg;
   logic [DATA_W-1:0] acc_next;
   logic              acc_en;
   logic              wr_stb_q, rd_req_q, oe_q;
   logic [REG_AW-1:0] wr_reg_q;
   logic [DATA_W-1:0] wr_data_q;

   assign byte_full = {dat_l, rx_hold};
   assign last_bit  = (bit_cnt == BCNT_W'(BYTE_W - 1));
   assign take_bit  = sclk_rise & ~mode_rise & ~mode_fall & awake;
   assign acc_en    = take_bit & mode_l & last_bit & (ses == SES_WDATA);

   tw_addr_decode #(.SEL_W(SEL_W), .DEV_HI_W(DEV_HI_W), .DEV_HI(DEV_HI)) u_dec (
      .byte_i (byte_full),
      .sel_i  (dev_sel_i),
      .xfer_o (xfer)
   );

   // value assembly: bytes arrive most significant first
   if (DATA_BYTES > 1) begin : g_multi
      logic [DATA_W-BYTE_W-1:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc_q <= '0;
         else if (acc_en) acc_q <= acc_next[DATA_W-BYTE_W-1:0];
      end
      assign acc_next = {acc_q, byte_full};
   end else begin : g_single
      assign acc_next = byte_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         awake       <= 1'b0;
         ses         <= SES_IDLE;
         bit_cnt     <= '0;
         rx_hold     <= '0;
         dbyte_cnt   <= '0;
         wr_reg_pend <= '0;
         prep_reg    <= '0;
         wr_stb_q    <= 1'b0;
         rd_req_q    <= 1'b0;
         oe_q        <= 1'b0;
         wr_reg_q    <= '0;
         wr_data_q   <= '0;
      end else begin
         wr_stb_q <= 1'b0;
         rd_req_q <= 1'b0;
         if (mode_fall) begin
            ses     <= SES_IDLE;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else if (mode_rise) begin
            bit_cnt <= '0;
            if (ses == SES_RDOUT) oe_q <= 1'b1;
         end else if (sclk_rise && !awake) begin
            awake <= 1'b1;
         end else if (take_bit) begin
            rx_hold <= byte_full[BYTE_W-1:1];
            if (!mode_l) begin
               // selection phase: exactly one byte counts
               if (bit_cnt < BCNT_W'(BYTE_W)) bit_cnt <= bit_cnt + 1'b1;
               if (last_bit) begin
                  case (xfer)
                     XFER_WRITE: ses <= SES_REGSEL;
                     XFER_READ: begin
                        ses      <= SES_RDOUT;
                        rd_req_q <= 1'b1;
                     end
                     default:    ses <= SES_IDLE;
                  endcase
               end
            end else begin
               bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
               if (last_bit) begin
                  case (ses)
                     SES_REGSEL: begin
                        if (!byte_full[0]) begin
                           wr_reg_pend <= byte_full[BYTE_W-1:1];
                           dbyte_cnt   <= '0;
                           ses         <= SES_WDATA;
                        end else begin
                           prep_reg <= byte_full[BYTE_W-1:1];
                           ses      <= SES_DONE;
                        end
                     end
                     SES_WDATA: begin
                        if (dbyte_cnt == DBC_W'(DATA_BYTES - 1)) begin
                           wr_stb_q  <= 1'b1;
                           wr_reg_q  <= wr_reg_pend;
                           wr_data_q <= acc_next;
                           ses       <= SES_DONE;
                        end else begin
                           dbyte_cnt <= dbyte_cnt + 1'b1;
                        end
                     end
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   // ---------------- transmit path ----------------
   logic [TX_W-1:0] tx_load;

   assign tx_load[0]          = ~rd_valid_i;
   assign tx_load[BYTE_W-1:1] = prep_reg;
   for (genvar k = 0; k < DATA_BYTES; k++) begin : g_txb
      assign tx_load[BYTE_W*(k+1) +: BYTE_W] = rd_data_i[DATA_W-1-BYTE_W*k -: BYTE_W];
   end

   tw_tx_shift #(.WIDTH(TX_W), .FILL(1'b1)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (rd_req_q),
      .load_val_i (tx_load),
      .shift_i    (sclk_fall & mode_l & oe_q),
      .bit_o      (ser_dat_o)
   );

   assign ser_dat_oe = oe_q;
   assign wr_stb_o   = wr_stb_q;
   assign wr_reg_o   = wr_reg_q;
   assign wr_data_o  = wr_data_q;
   assign rd_req_o   = rd_req_q;
   assign rd_reg_o   = prep_reg;

endmodule

// File: rtl/tw_ctrl_slave_chk.sv
module tw_ctrl_slave_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_l,
   input logic              mode_rise,
   input logic              sclk_fall,
   input logic              awake,
   input logic              ser_dat_o,
   input logic              ser_dat_oe,
   input logic              wr_stb_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              rd_req_o
);

   // R9
   oe_in_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_dat_oe |-> $past(mode_l));

   // R9
   oe_rise_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_dat_oe) |-> $past(mode_rise));

   // R5
   wr_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);

   // R8
   rd_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

   // R1
   asleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !awake |-> (!wr_stb_o && !rd_req_o));

   // R11
   wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_data_o) |-> wr_stb_o);

   // R8
   tx_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_dat_oe && $past(ser_dat_oe) && !$past(sclk_fall)) |-> $stable(ser_dat_o));

endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_l     (mode_l),
   .mode_rise  (mode_rise),
   .sclk_fall  (sclk_fall),
   .awake      (awake),
   .ser_dat_o  (ser_dat_o),
   .ser_dat_oe (ser_dat_oe),
   .wr_stb_o   (wr_stb_o),
   .wr_data_o  (wr_data_o),
   .rd_req_o   (rd_req_o)
);

// File: tb/tw_ctrl_slave_test.sv
`timescale 1ns/1ps
module tw_ctrl_slave_test;

   localparam int HP = 6; // system clocks per serial half period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk, smode, sdat;
   logic        ser_dat_o, ser_dat_oe;
   logic [1:0]  dev_sel;
   logic        wr_stb_o, rd_req_o;
   logic [6:0]  wr_reg_o, rd_reg_o;
   logic [15:0] wr_data_o, rd_data_i;
   logic        rd_valid_i;

   always #10 clk = ~clk;

   tw_ctrl_slave uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk_i  (sclk),
      .ser_mode_i (smode),
      .ser_dat_i  (sdat),
      .ser_dat_o  (ser_dat_o),
      .ser_dat_oe (ser_dat_oe),
      .dev_sel_i  (dev_sel),
      .wr_stb_o   (wr_stb_o),
      .wr_reg_o   (wr_reg_o),
      .wr_data_o  (wr_data_o),
      .rd_req_o   (rd_req_o),
      .rd_reg_o   (rd_reg_o),
      .rd_data_i  (rd_data_i),
      .rd_valid_i (rd_valid_i)
   );

   // register bank model: registers 0..39 exist
   function automatic logic [15:0] bank_val(input logic [6:0] r);
      return {r, 9'h0A5};
   endfunction
   assign rd_valid_i = (rd_reg_o < 7'd40);
   assign rd_data_i  = bank_val(rd_reg_o);

   int   checks = 0;
   int   fails  = 0;
   int   stb_cnt = 0;
   int   req_cnt = 0;
   logic oe_seen = 1'b0;

   always @(negedge clk) begin
      if (wr_stb_o)   stb_cnt++;
      if (rd_req_o)   req_cnt++;
      if (ser_dat_oe) oe_seen = 1'b1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ser_bit(input logic b);
      sdat = b;
      tick(HP);
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
   endtask

   task automatic recv_bit(output logic b);
      sdat = 1'b0;
      tick(HP);
      b = ser_dat_o;
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) ser_bit(b[i]);
   endtask

   task automatic recv_byte(output logic [7:0] b);
      for (int i = 0; i < 8; i++) recv_bit(b[i]);
   endtask

   function automatic logic [7:0] sel_byte(input logic [1:0] code, input logic [1:0] sel);
      return {4'b0001, sel, code};
   endfunction

   task automatic begin_sel(input logic [7:0] ab);
      tick(HP);
      smode = 1'b0;
      tick(2*HP);
      send_byte(ab);
      tick(HP);
      smode = 1'b1;
      tick(2*HP);
   endtask

   task automatic close_frame();
      tick(HP);
      smode = 1'b0;
      tick(2*HP);
   endtask

   task automatic write_raw(input logic [7:0] ab, input logic [6:0] r, input logic [15:0] d);
      begin_sel(ab);
      send_byte({r, 1'b0});
      send_byte(d[15:8]);
      send_byte(d[7:0]);
      close_frame();
   endtask

   task automatic t_reset();
      chk("R11 wr_data after reset", 32'(wr_data_o), 32'h0);
      chk("R11 wr_reg after reset", 32'(wr_reg_o), 32'h0);
      chk("R9 oe after reset", 32'(ser_dat_oe), 32'h0);
      chk("R5 strobe after reset", 32'(wr_stb_o), 32'h0);
   endtask

   task automatic t_wake();
      int s0 = stb_cnt;
      write_raw(sel_byte(2'b10, dev_sel), 7'h11, 16'h5A5A);
      chk("R1 frame over wake edge ignored", 32'(stb_cnt), 32'(s0));
      write_raw(sel_byte(2'b10, dev_sel), 7'h11, 16'h5A5A);
      chk("R1 write after wake accepted", 32'(stb_cnt), 32'(s0 + 1));
      chk("R1 value after wake", 32'(wr_data_o), 32'h5A5A);
   endtask

   task automatic t_write();
      int s0 = stb_cnt;
      oe_seen = 1'b0;
      write_raw(sel_byte(2'b10, dev_sel), 7'h2B, 16'hBEEF);
      chk("R5 one strobe", 32'(stb_cnt), 32'(s0 + 1));
      chk("R2 R5 register number", 32'(wr_reg_o), 32'h2B);
      chk("R2 R5 value", 32'(wr_data_o), 32'hBEEF);
      chk("R9 no drive on write", 32'(oe_seen), 32'h0);
   endtask

   task automatic t_extra();
      int s0 = stb_cnt;
      begin_sel(sel_byte(2'b10, dev_sel));
      send_byte({7'h03, 1'b0});
      send_byte(8'h12);
      send_byte(8'h34);
      send_byte(8'h56);
      send_byte(8'h78);
      send_byte(8'h9A);
      close_frame();
      chk("R6 single strobe", 32'(stb_cnt), 32'(s0 + 1));
      chk("R6 value kept", 32'(wr_data_o), 32'h1234);
      chk("R6 register kept", 32'(wr_reg_o), 32'h03);
   endtask

   task automatic t_match();
      int s0 = stb_cnt;
      write_raw(sel_byte(2'b10, 2'b01), 7'h44, 16'h0F0F);
      write_raw({4'b0011, dev_sel, 2'b10}, 7'h44, 16'h0F0F);
      chk("R3 mismatched address ignored", 32'(stb_cnt), 32'(s0));
      chk("R11 value held after ignored frames", 32'(wr_data_o), 32'h1234);
      dev_sel = 2'b01;
      write_raw(sel_byte(2'b10, 2'b01), 7'h44, 16'h0F0F);
      chk("R3 new pin address accepted", 32'(stb_cnt), 32'(s0 + 1));
      chk("R3 value", 32'(wr_data_o), 32'h0F0F);
      dev_sel = 2'b10;
   endtask

   task automatic t_types();
      int s0 = stb_cnt;
      int r0 = req_cnt;
      write_raw(sel_byte(2'b00, dev_sel), 7'h05, 16'hAAAA);
      write_raw(sel_byte(2'b01, dev_sel), 7'h05, 16'hAAAA);
      chk("R4 unused codes no write", 32'(stb_cnt), 32'(s0));
      chk("R4 unused codes no read", 32'(req_cnt), 32'(r0));
      chk("R4 value held", 32'(wr_data_o), 32'h0F0F);
   endtask

   task automatic t_short();
      int s0 = stb_cnt;
      logic [7:0] ab = sel_byte(2'b10, dev_sel);
      tick(HP);
      smode = 1'b0;
      tick(2*HP);
      for (int i = 0; i < 5; i++) ser_bit(ab[i]);
      tick(HP);
      smode = 1'b1;
      tick(2*HP);
      send_byte({7'h06, 1'b0});
      send_byte(8'h77);
      send_byte(8'h66);
      close_frame();
      chk("R10 short selection ignored", 32'(stb_cnt), 32'(s0));
      chk("R10 value held", 32'(wr_data_o), 32'h0F0F);
   endtask

   task automatic t_read(input logic [6:0] r);
      int s0 = stb_cnt;
      int r0;
      logic [7:0] b0, b1, b2;
      logic [15:0] ev = bank_val(r);
      logic flag = (r < 7'd40) ? 1'b0 : 1'b1;
      begin_sel(sel_byte(2'b10, dev_sel));
      send_byte({r, 1'b1});
      close_frame();
      chk("R7 prepare gives no strobe", 32'(stb_cnt), 32'(s0));
      chk("R7 prepared register", 32'(rd_reg_o), 32'(r));
      r0 = req_cnt;
      begin_sel(sel_byte(2'b11, dev_sel));
      chk("R8 one read request", 32'(req_cnt), 32'(r0 + 1));
      chk("R9 drive during read", 32'(ser_dat_oe), 32'h1);
      recv_byte(b0);
      recv_byte(b1);
      recv_byte(b2);
      chk("R8 echo byte with flag", 32'(b0), 32'({r, flag}));
      chk("R8 high data byte", 32'(b1), 32'(ev[15:8]));
      chk("R8 low data byte", 32'(b2), 32'(ev[7:0]));
      close_frame();
      chk("R9 drive released", 32'(ser_dat_oe), 32'h0);
   endtask

   initial begin
      sclk = 1'b0;
      smode = 1'b1;
      sdat = 1'b0;
      dev_sel = 2'b10;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_wake();
      t_write();
      t_extra();
      t_match();
      t_types();
      t_short();
      t_read(7'h12);
      t_read(7'h50);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #4000000;
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule